// File: doc/BRIEF.md
# I2C Register-Port Target with Word-Granular Auto-Increment

This block is an I2C target that lets an external host reach an on-chip register and memory space through a 16-bit subaddress. Each transaction opens with the chip address and a write bit. Two bytes then load the subaddress, most significant byte first. In a write, the data bytes that follow are collected into words. Each complete word is handed to the register bus as a single strobe. In a read, the host issues a repeated start and the chip address with the read bit. The block then fetches words from the register bus and shifts them out, most significant byte first.

The word length, from 1 to 5 bytes, is decoded from the region that the current subaddress falls in. The subaddress advances by one only after a whole word has moved in either direction. SCL and SDA are brought into the system clock domain through a synchronizer. The open-drain output only ever pulls SDA low, and it changes only while SCL is low. The chip address is a plain 7-bit input.

The register-bus edges carry no back-pressure, because the I2C bus itself cannot be held. The write sink must take every `wr_valid` pulse. The read responder must raise `rd_rsp_valid` once for each `rd_req_valid`, before the next falling SCL edge.

Top module: `i2c_regport`

## Requirements
- R1: An address byte whose upper 7 bits equal `dev_addr` is acknowledged by pulling SDA low on the ninth clock. If they differ, SDA stays released and no strobe or request appears until the next start condition.
- R2: With a matching address, every received byte is acknowledged on its ninth clock. This covers the address byte, both subaddress bytes and each write data byte.
- R3: After a write-mode address, the first byte sets subaddress bits 15:8 and the second sets bits 7:0. The first word written goes to that subaddress.
- R4: Word length in bytes by subaddress: below 0x0400 it is 4; 0x0400 to 0x07FF it is 5; 0x0800 to 0x08FF it is 2; 0x0900 to 0x09FF it is 1; from 0x0A00 up it is 3.
- R5: After the last byte of a write word, `wr_valid` pulses for one cycle. `wr_addr` carries the word's subaddress. `wr_data` carries the word right-aligned, with the first byte received most significant and all bits above the word length zero. The subaddress then advances by one.
- R6: A write word that is cut short by a stop condition produces no strobe.
- R7: A read-mode address after a repeated start makes the block issue `rd_req_valid` with `rd_req_addr` equal to the current subaddress. It then sends the returned word, most significant byte first and most significant bit first. Only the low 8×length bits of `rd_rsp_data` are used.
- R8: When the host acknowledges the last byte of a read word, the block requests the next subaddress (previous + 1) and continues with that word.
- R9: When the host does not acknowledge a read byte, SDA stays released and no further read request is made before the next stop or start.
- R10: `sda_oe` changes only while SCL is low, except on the release at a start or stop condition.
- R11: A start condition seen while SCL is high and SDA falls restarts address reception from any state. This includes a repeated start in the middle of a transaction.
- R12: After reset, SDA is released and neither `wr_valid` nor `rd_req_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Chip address this target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Subaddress of the written word |
| wr_data | output | 40 | Written word, right-aligned |
| rd_req_valid | output | 1 | One-cycle read request |
| rd_req_addr | output | 16 | Subaddress to fetch |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_data | input | 40 | Fetched word, right-aligned |

## Verification
The checker assumes the following about the host:
- It moves SDA only while SCL is low, apart from start and stop conditions.
- It keeps each SCL phase long enough to survive the two-stage synchronizer.

The checker also assumes that the read responder answers well inside one SCL high phase. The stimulus meets all of these conditions: each SCL phase lasts ten system clocks, the host changes SDA midway through the low phase, and the responder replies two cycles after each request. Under these conditions, a one-cycle write or request pulse can never repeat on the next cycle.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUBH,
    ST_SUBL,
    ST_WDATA,
    ST_RDATA,
    ST_RWAIT,
    ST_SKIP
  } port_state_e;

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // Synchronizer chain, one generate stage per flop
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic scl_q;
    logic sda_q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= g_stage[i-1].scl_q;
          sda_q <= g_stage[i-1].sda_q;
        end
      end
    end
  end

  logic scl_prev, sda_prev;

  assign scl_lvl = g_stage[STAGES-1].scl_q;
  assign sda_lvl = g_stage[STAGES-1].sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_regport_len_dec.sv
module i2c_regport_len_dec #(
  parameter int          LEN_W    = 3,
  parameter logic [15:0] A_END    = 16'h0400,
  parameter int          A_LEN    = 4,
  parameter logic [15:0] B_END    = 16'h0800,
  parameter int          B_LEN    = 5,
  parameter logic [15:0] C_END    = 16'h0900,
  parameter int          C_LEN    = 2,
  parameter logic [15:0] D_END    = 16'h0A00,
  parameter int          D_LEN    = 1,
  parameter int          TAIL_LEN = 3
) (
  input  logic [15:0]      addr,
  output logic [LEN_W-1:0] len
);

  always_comb begin
    if (addr < A_END)      len = LEN_W'(A_LEN);
    else if (addr < B_END) len = LEN_W'(B_LEN);
    else if (addr < C_END) len = LEN_W'(C_LEN);
    else if (addr < D_END) len = LEN_W'(D_LEN);
    else                   len = LEN_W'(TAIL_LEN);
  end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int MAX_BYTES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [6:0]             dev_addr,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic                   wr_valid,
  output logic [15:0]            wr_addr,
  output logic [8*MAX_BYTES-1:0] wr_data,
  output logic                   rd_req_valid,
  output logic [15:0]            rd_req_addr,
  input  logic                   rd_rsp_valid,
  input  logic [8*MAX_BYTES-1:0] rd_rsp_data
);
  import i2c_regport_pkg::*;

  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  port_state_e       state;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sr, tx_sr;
  logic [15:0]       sub_addr;
  logic [LEN_W-1:0]  byte_idx, word_len, last_idx;
  logic [DATA_W-1:0] wbuf, rbuf, wnext;
  logic              tx_go;
  logic              rx_phase, active;

  i2c_regport_len_dec #(.LEN_W(LEN_W)) u_len (
    .addr (sub_addr),
    .len  (word_len)
  );

  assign last_idx = word_len - LEN_W'(1);
  assign wnext    = {wbuf[DATA_W-9:0], rx_sr};
  assign rx_phase = (state == ST_ADDR) || (state == ST_SUBH) ||
                    (state == ST_SUBL) || (state == ST_WDATA);
  assign active   = rx_phase || (state == ST_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sr        <= '0;
      tx_sr        <= '0;
      sub_addr     <= '0;
      byte_idx     <= '0;
      wbuf         <= '0;
      rbuf         <= '0;
      tx_go        <= 1'b0;
      sda_oe       <= 1'b0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
    end else begin
      wr_valid     <= 1'b0;
      rd_req_valid <= 1'b0;
      if (rd_rsp_valid)
        rbuf <= rd_rsp_data << (8 * (MAX_BYTES - int'(word_len)));

      if (start_det || stop_det) begin
        state    <= start_det ? ST_ADDR : ST_IDLE;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        byte_idx <= '0;
        wbuf     <= '0;
        tx_go    <= 1'b0;
      end else if (scl_rise && active) begin
        if (bit_cnt < 4'd8) begin
          if (rx_phase) rx_sr <= {rx_sr[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          // host acknowledge slot of a transmitted byte
          if (state == ST_RDATA && !tx_go) begin
            if (!sda_lvl) begin
              tx_go <= 1'b1;
              if (byte_idx == last_idx) begin
                byte_idx     <= '0;
                sub_addr     <= sub_addr + 16'd1;
                rd_req_valid <= 1'b1;
                rd_req_addr  <= sub_addr + 16'd1;
              end else begin
                byte_idx <= byte_idx + LEN_W'(1);
              end
            end else begin
              state <= ST_RWAIT;
            end
          end
        end
      end else if (scl_fall && active) begin
        if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
          if (state == ST_RDATA) sda_oe <= ~tx_sr[3'd7 - bit_cnt[2:0]];
        end else if (bit_cnt == 4'd8) begin
          case (state)
            ST_ADDR: begin
              if (rx_sr[7:1] == dev_addr) begin
                sda_oe <= 1'b1;
                if (rx_sr[0]) begin
                  state        <= ST_RDATA;
                  tx_go        <= 1'b1;
                  byte_idx     <= '0;
                  rd_req_valid <= 1'b1;
                  rd_req_addr  <= sub_addr;
                end else begin
                  state <= ST_SUBH;
                end
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_SUBH: begin
              sda_oe         <= 1'b1;
              sub_addr[15:8] <= rx_sr;
              state          <= ST_SUBL;
            end
            ST_SUBL: begin
              sda_oe        <= 1'b1;
              sub_addr[7:0] <= rx_sr;
              byte_idx      <= '0;
              wbuf          <= '0;
              state         <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_oe <= 1'b1;
              if (byte_idx == last_idx) begin
                wr_valid <= 1'b1;
                wr_addr  <= sub_addr;
                wr_data  <= wnext;
                wbuf     <= '0;
                byte_idx <= '0;
                sub_addr <= sub_addr + 16'd1;
              end else begin
                wbuf     <= wnext;
                byte_idx <= byte_idx + LEN_W'(1);
              end
            end
            ST_RDATA: sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          if (state == ST_RDATA && tx_go) begin
            tx_sr  <= rbuf[DATA_W-1 -: 8];
            rbuf   <= rbuf << 8;
            sda_oe <= ~rbuf[DATA_W-1];
            tx_go  <= 1'b0;
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int MAX_BYTES = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          scl_lvl,
  input logic                          start_det,
  input logic                          stop_det,
  input logic                          sda_oe,
  input logic                          wr_valid,
  input logic [15:0]                   wr_addr,
  input logic [8*MAX_BYTES-1:0]        wr_data,
  input logic                          rd_req_valid,
  input i2c_regport_pkg::port_state_e  state
);
  import i2c_regport_pkg::*;

  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  logic [LEN_W-1:0] wr_len;

  i2c_regport_len_dec #(.LEN_W(LEN_W)) u_chk_len (
    .addr (wr_addr),
    .len  (wr_len)
  );

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det))); // R10

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R5

  AST_WR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data >> (8 * int'(wr_len))) == '0)); // R5

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> !rd_req_valid); // R8

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!sda_oe && !wr_valid && !rd_req_valid)); // R1

  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RWAIT) |-> (!sda_oe && !rd_req_valid)); // R9

endmodule

bind i2c_regport i2c_regport_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_lvl      (scl_lvl),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .sda_oe       (sda_oe),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rd_req_valid (rd_req_valid),
  .state        (state)
);

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;

  localparam logic [6:0] DEV = 7'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m_low = 1'b0;
  logic        sda_line;
  logic        sda_oe;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [39:0] wr_data;
  logic        rd_req_valid;
  logic [15:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [39:0] rd_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  int rd_req_cnt = 0;
  int sda_violations = 0;
  bit done = 1'b0;

  logic [15:0] exp_addr_q[$];
  logic [39:0] exp_data_q[$];
  logic [7:0]  bq[$];

  always #2.5 clk = ~clk;

  assign sda_line = ~(sda_m_low | sda_oe);

  i2c_regport u_i2c_regport (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_addr     (DEV),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe       (sda_oe),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data)
  );

  // R4 region table
  function automatic int blen(input logic [15:0] a);
    if (a < 16'h0400) return 4;
    if (a < 16'h0800) return 5;
    if (a < 16'h0900) return 2;
    if (a < 16'h0A00) return 1;
    return 3;
  endfunction

  function automatic logic [39:0] pattern(input logic [15:0] a);
    logic [39:0] m;
    m = (40'd1 << (8 * blen(a))) - 40'd1;
    return {a[7:0] ^ 8'h5A, a[15:8], a[7:0] + 8'h11, 8'hC3, a[7:0]} & m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock reference comparison: strobes, SDA timing, read responder
  initial begin
    logic prev_oe;
    int   pend;
    logic [15:0] pa;
    prev_oe = 1'b0;
    pend = 0;
    pa = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (rst_n) begin
        if (sda_oe != prev_oe && scl_m) begin
          sda_violations++;
          failures++;
          $display("FAIL R10 actual=sda_oe moved with SCL high expected=stable");
        end
        prev_oe = sda_oe;
        if (wr_valid) begin
          if (exp_addr_q.size() == 0) begin
            check(1'b0, "R6 unexpected write strobe", {24'd0, wr_addr}, 40'd0);
          end else begin
            check(wr_addr == exp_addr_q[0], "R3 R5 write address", {24'd0, wr_addr}, {24'd0, exp_addr_q[0]});
            check(wr_data == exp_data_q[0], "R5 write data", wr_data, exp_data_q[0]);
            void'(exp_addr_q.pop_front());
            void'(exp_data_q.pop_front());
          end
        end
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = pattern(pa);
          end
        end
        if (rd_req_valid) begin
          rd_req_cnt++;
          pa = rd_req_addr;
          pend = 2;
        end
      end
    end
  end

  task automatic i2c_start();
    if (!scl_m) begin
      w(5); sda_m_low = 1'b0; w(5); scl_m = 1'b1; w(10);
    end
    sda_m_low = 1'b1; w(10); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    w(5); sda_m_low = 1'b1; w(5); scl_m = 1'b1; w(10); sda_m_low = 1'b0; w(10);
  endtask

  task automatic send_bit(input logic v);
    w(5); sda_m_low = ~v; w(5); scl_m = 1'b1; w(10); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(5); sda_m_low = 1'b0; w(5); scl_m = 1'b1; w(5);
    ack = ~sda_line;
    w(5); scl_m = 1'b0;
    check(ack == exp_ack, req, {39'd0, ack}, {39'd0, exp_ack});
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    b = '0;
    sda_m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      w(10); scl_m = 1'b1; w(5); b = {b[6:0], sda_line}; w(5); scl_m = 1'b0;
    end
    w(5); sda_m_low = mack; w(5); scl_m = 1'b1; w(10); scl_m = 1'b0; w(2); sda_m_low = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] addr);
    logic [15:0] a;
    logic [39:0] acc;
    int k;
    a = addr; acc = '0; k = 0;
    foreach (bq[i]) begin
      acc = (acc << 8) | {32'd0, bq[i]};
      k++;
      if (k == blen(a)) begin
        exp_addr_q.push_back(a);
        exp_data_q.push_back(acc);
        a++; acc = '0; k = 0;
      end
    end
    i2c_start();
    write_byte({DEV, 1'b0}, 1'b1, "R1 address ack");
    write_byte(addr[15:8], 1'b1, "R2 subaddress high ack");
    write_byte(addr[7:0], 1'b1, "R2 subaddress low ack");
    foreach (bq[i]) write_byte(bq[i], 1'b1, "R2 data ack");
    i2c_stop();
    w(20);
    check(exp_addr_q.size() == 0, "R5 R6 strobe count", 40'(exp_addr_q.size()), 40'd0);
    exp_addr_q.delete();
    exp_data_q.delete();
  endtask

  task automatic do_read(input logic [15:0] addr, input int n);
    logic [15:0] a;
    int k, l;
    logic [7:0] got, exp;
    a = addr; k = 0;
    i2c_start();
    write_byte({DEV, 1'b0}, 1'b1, "R1 address ack");
    write_byte(addr[15:8], 1'b1, "R3 subaddress high ack");
    write_byte(addr[7:0], 1'b1, "R3 subaddress low ack");
    rd_req_cnt = 0;
    i2c_start();  // repeated start, R11
    write_byte({DEV, 1'b1}, 1'b1, "R11 read address ack");
    for (int i = 0; i < n; i++) begin
      l = blen(a);
      exp = 8'(pattern(a) >> (8 * (l - 1 - k)));
      read_byte(i != n - 1, got);
      check(got == exp, "R7 R8 read byte", {32'd0, got}, {32'd0, exp});
      k++;
      if (k == l) begin a++; k = 0; end
    end
    w(10);
    check(sda_oe == 1'b0, "R9 released after nack", {39'd0, sda_oe}, 40'd0);
    i2c_stop();
    w(10);
    check(rd_req_cnt == 1 + (n - 1) / blen(addr), "R8 R9 request count",
          40'(rd_req_cnt), 40'(1 + (n - 1) / blen(addr)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    w(4);
    check(sda_oe == 1'b0, "R12 sda released in reset", {39'd0, sda_oe}, 40'd0);
    rst_n = 1'b1;
    w(6);
    check(!wr_valid && !rd_req_valid && !sda_oe, "R12 idle after reset",
          {37'd0, wr_valid, rd_req_valid, sda_oe}, 40'd0);

    bq = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    do_write(16'h0800);                       // R4 two-byte region
    bq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    do_write(16'h0010);                       // R6 trailing partial word
    bq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    do_write(16'h0400);                       // R4 five-byte region
    bq = '{8'h9A, 8'h9B, 8'h9C};
    do_write(16'h0900);                       // R4 one-byte region
    bq = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
    do_write(16'h2000);                       // R4 three-byte tail, R6 partial

    // R1 mismatched chip address: no ack anywhere, no strobe
    i2c_start();
    write_byte({7'h21, 1'b0}, 1'b0, "R1 mismatch no ack");
    write_byte(8'h08, 1'b0, "R1 ignored byte");
    write_byte(8'h00, 1'b0, "R1 ignored byte");
    i2c_stop();
    w(20);

    do_read(16'h0802, 4);
    do_read(16'h0405, 6);
    do_read(16'h0903, 3);
    do_read(16'h3000, 2);

    check(sda_violations == 0, "R10 sda timing", 40'(sda_violations), 40'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule